// File: doc/BRIEF.md
# Serial Operation Timing Controller

This block sits beside a bit-serial datapath whose 32-bit words circulate one bit per clock. An external pulse-position counter marks the bit slot (P1..P32). The block takes a 4-bit operation-type code and a start strobe. It captures the code and opens a timing window aligned to the word structure. While the window is open it raises the enable of the selected operation type, so the matching datapath acts for exactly the right bit periods.

The rule that closes the window depends on the type class:
- **Fixed-length types** (one full word, or half a word for the single mid-word type) close on their own.
- **Storage-transfer types** close when the address-match window for the requested word slot ends.
- **Card-transfer types** close on a card-exit event.
- **Arithmetic type** closes on an arithmetic-finished signal.

Event-driven closes are always deferred to the next P32, so every window ends on a word boundary.

The controller is a three-state machine:
- `ST_IDLE`: waiting for an accepted start.
- `ST_ARMED`: start accepted, waiting for the opening bit slot.
- `ST_OPEN`: window active.

Its transitions are:
- *accept_direct*: `ST_IDLE` to `ST_OPEN`, when the strobe arrives in the slot just before the opening slot.
- *accept_wait*: `ST_IDLE` to `ST_ARMED`.
- *align*: `ST_ARMED` to `ST_OPEN`, on the slot before the opening slot.
- *close*: `ST_OPEN` to `ST_IDLE`, at a P32 once the type's closing condition holds.

Top module: `sop_window_ctrl`

## Requirements
- R1: The code maps to one-hot bit `type_en[code]` for codes 0..9, named K=0, L=1, M=2, N=3, O=4, P=5, Q=6, R=7, S=8, T=9. The upper three code bits pick a pair, and the low bit picks the member of the pair.
- R2: The window first goes high in the first cycle with `pulse_pos`=0 (P1) after an accepted start. For code 6 (Q) it first goes high in the first cycle with `pulse_pos`=16 (P17).
- R3: Once open, the window stays high through the next cycle with `pulse_pos`=31 (P32). It falls only in the cycle right after a P32 cycle.
- R4: Codes 2, 3, 7 and 9 (M, N, R, T) hold the window for exactly 32 cycles.
- R5: Code 6 (Q) holds the window for exactly 16 cycles, P17 through P32.
- R6: Codes 0 and 1 (K, L) close the window after the P32 of the word during which `addr_match` is high.
- R7: Codes 4 and 5 (O, P) close the window after the P32 of the word in which `card_exit` was seen while the window was open.
- R8: Code 8 (S) closes the window after the P32 of the word in which `arith_done` was seen while the window was open.
- R9: `type_en` is the decoded captured type ANDed with the window. At most one bit is high, and none is high while the window is low.
- R10: A start strobe that arrives while `busy` is high has no effect on the window, its length or the active enable.
- R11: A start with code 10..15 leaves `busy`, `window` and `type_en` all low.
- R12: `busy` is high from the cycle after an accepted start until the window closes. All outputs are low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Operation-type code, sampled with `start` |
| start | input | 1 | Start strobe |
| pulse_pos | input | 5 | Bit slot in the word, 0 = P1 .. 31 = P32 |
| addr_match | input | 1 | High during the word slot that matches the requested address |
| card_exit | input | 1 | Card has left the mechanism |
| arith_done | input | 1 | Arithmetic operation finished |
| type_en | output | 10 | Per-type enable, bit index = code |
| window | output | 1 | Operation timing window |
| busy | output | 1 | Start accepted and window not yet closed |

## Verification
On every cycle the assertions check four things:
- The window opens only on a P1 or P17.
- Once open, it never drops before a P32.
- A match-closed window ends only after a cycle with `addr_match` high.
- Enables stay one-hot under the window, and strobes that are unused or arrive while busy change nothing.

Only the bench scenarios can show the actual window lengths per type: the 32- and 16-cycle windows, multi-word windows ending at the matching slot, and windows stretched until a card or arithmetic event. The bench's cycle-by-cycle reference model also confirms the exact opening cycle after strobes at arbitrary bit positions.

// File: rtl/sop_pkg.sv
package sop_pkg;
    localparam int NUM_TYPES = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_OPEN  = 2'd2
    } sop_state_t;

    typedef enum logic [1:0] {
        CL_FIXED = 2'd0,
        CL_MATCH = 2'd1,
        CL_CARD  = 2'd2,
        CL_ARITH = 2'd3
    } sop_close_t;
endpackage

// File: rtl/sop_type_dec.sv
module sop_type_dec
    import sop_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int N_TYPES = NUM_TYPES
) (
    input  logic [CODE_W-1:0]  code,
    output logic               valid,
    output logic               half_word,
    output sop_close_t         rule,
    output logic [N_TYPES-1:0] onehot
);
    localparam int PAIR_W = CODE_W - 1;

    logic [PAIR_W-1:0] pair_sel;
    logic              member;

    assign pair_sel = code[CODE_W-1:1];
    assign member   = code[0];

    // Pair select plus member bit gives type index 2*pair + member.
    genvar gi;
    generate
        for (gi = 0; gi < N_TYPES; gi++) begin : g_dec
            assign onehot[gi] = (pair_sel == PAIR_W'(gi / 2)) && (member == gi[0]);
        end
    endgenerate

    assign valid     = |onehot;
    assign half_word = onehot[6];

    always_comb begin
        if (onehot[0] || onehot[1])
            rule = CL_MATCH;
        else if (onehot[4] || onehot[5])
            rule = CL_CARD;
        else if (onehot[8])
            rule = CL_ARITH;
        else
            rule = CL_FIXED;
    end
endmodule

// File: rtl/sop_window_fsm.sv
module sop_window_fsm
    import sop_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int POS_W = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             live_valid,
    input  logic             live_half,
    input  logic             held_half,
    input  sop_close_t       held_rule,
    input  logic [POS_W-1:0] pos,
    input  logic             addr_match,
    input  logic             card_exit,
    input  logic             arith_done,
    output logic             accept,
    output logic             window,
    output logic             busy
);
    localparam logic [POS_W-1:0] LAST_SLOT = POS_W'(WORD_BITS - 1);
    localparam logic [POS_W-1:0] MID_PRE   = POS_W'(WORD_BITS / 2 - 1);
    localparam logic [POS_W-1:0] MID_SLOT  = POS_W'(WORD_BITS / 2);

    sop_state_t st_q, st_d;
    logic       pend_q;
    logic       live_pre, held_pre, event_in, close_ok, at_last;

    assign at_last  = (pos == LAST_SLOT);
    assign live_pre = live_half ? (pos == MID_PRE) : at_last;
    assign held_pre = held_half ? (pos == MID_PRE) : at_last;
    assign accept   = start && live_valid && (st_q == ST_IDLE);

    always_comb begin
        unique case (held_rule)
            CL_CARD:  event_in = card_exit;
            CL_ARITH: event_in = arith_done;
            default:  event_in = 1'b0;
        endcase
    end

    always_comb begin
        unique case (held_rule)
            CL_FIXED: close_ok = 1'b1;
            CL_MATCH: close_ok = addr_match;
            CL_CARD,
            CL_ARITH: close_ok = pend_q || event_in;
            default:  close_ok = 1'b1;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = live_pre ? ST_OPEN : ST_ARMED;
            ST_ARMED: if (held_pre) st_d = ST_OPEN;
            ST_OPEN:  if (at_last && close_ok) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept)
                pend_q <= 1'b0;
            else if (st_q == ST_OPEN && event_in)
                pend_q <= 1'b1;
        end
    end

    always_comb begin
        window = (st_q == ST_OPEN);
        busy   = (st_q != ST_IDLE);
    end

    assert_open_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window) |-> (pos == '0 || pos == MID_SLOT));

    assert_hold_to_p32_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (window && !at_last) |=> window);

    assert_close_after_p32_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(window) |-> $past(pos) == LAST_SLOT);

    assert_match_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (window && at_last && held_rule == CL_MATCH && !addr_match) |=> window);
endmodule

// File: rtl/sop_window_ctrl.sv
module sop_window_ctrl
    import sop_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int CODE_W = 4,
    parameter int N_TYPES = NUM_TYPES,
    parameter int POS_W = $clog2(WORD_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  op_code,
    input  logic               start,
    input  logic [POS_W-1:0]   pulse_pos,
    input  logic               addr_match,
    input  logic               card_exit,
    input  logic               arith_done,
    output logic [N_TYPES-1:0] type_en,
    output logic               window,
    output logic               busy
);
    logic [CODE_W-1:0]  held_code;
    logic               live_valid, live_half, held_valid, held_half, accept;
    sop_close_t         live_rule, held_rule;
    logic [N_TYPES-1:0] live_oh, held_oh;

    sop_type_dec #(.CODE_W(CODE_W), .N_TYPES(N_TYPES)) u_live_dec (
        .code(op_code), .valid(live_valid), .half_word(live_half),
        .rule(live_rule), .onehot(live_oh)
    );

    sop_type_dec #(.CODE_W(CODE_W), .N_TYPES(N_TYPES)) u_held_dec (
        .code(held_code), .valid(held_valid), .half_word(held_half),
        .rule(held_rule), .onehot(held_oh)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_code <= '0;
        else if (accept)
            held_code <= op_code;
    end

    sop_window_fsm #(.WORD_BITS(WORD_BITS), .POS_W(POS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .live_valid(live_valid), .live_half(live_half),
        .held_half(held_half), .held_rule(held_rule),
        .pos(pulse_pos), .addr_match(addr_match),
        .card_exit(card_exit), .arith_done(arith_done),
        .accept(accept), .window(window), .busy(busy)
    );

    assign type_en = window ? held_oh : '0;

    assert_enable_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(type_en));

    assert_enable_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (type_en != '0) |-> window);

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(held_code));

    assert_unused_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !live_valid) |=> !busy);

    assert_held_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> held_valid);

    logic unused_ok;
    assign unused_ok = ^{live_rule, live_oh};
endmodule

// File: tb/sop_window_ctrl_bench.sv
module sop_window_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = '0;
    logic       start = 1'b0;
    logic [4:0] pos = '0;
    logic       addr_match = 1'b0;
    logic       card_exit = 1'b0;
    logic       arith_done = 1'b0;
    logic [9:0] type_en;
    logic       window, busy;

    int checks = 0;
    int errors = 0;
    int word_cnt = 0;
    int slot = 3;
    bit done = 0;

    always #2 clk = ~clk;

    sop_window_ctrl u_sop_window_ctrl (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .start(start),
        .pulse_pos(pos), .addr_match(addr_match), .card_exit(card_exit),
        .arith_done(arith_done), .type_en(type_en), .window(window), .busy(busy)
    );

    // free-running bit slot counter, changed just after the edge
    always @(posedge clk) begin
        #1;
        if (pos == 5'd31) begin
            pos = '0;
            word_cnt++;
        end else begin
            pos = pos + 5'd1;
        end
        addr_match = ((word_cnt % 8) == slot);
    end

    // behavioural reference: 0 idle, 1 waiting for opening slot, 2 window open
    int m_st = 0;
    int m_type = 0;
    bit m_pend = 0;

    function automatic int pre_slot(input int t);
        return (t == 6) ? 15 : 31;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            m_pend = 0;
        end else begin
            case (m_st)
                0: if (start && op_code < 10) begin
                    m_type = op_code;
                    m_pend = 0;
                    m_st = (pos == pre_slot(m_type)) ? 2 : 1;
                end
                1: if (pos == pre_slot(m_type)) m_st = 2;
                default: begin
                    bit ev, ok;
                    ev = (m_type == 4 || m_type == 5) ? card_exit :
                         (m_type == 8) ? arith_done : 1'b0;
                    if (m_type == 0 || m_type == 1) ok = addr_match;
                    else if (m_type == 4 || m_type == 5 || m_type == 8) ok = m_pend || ev;
                    else ok = 1;
                    if (ev) m_pend = 1;
                    if (pos == 31 && ok) m_st = 0;
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ew, eb;
            logic [9:0] ee;
            ew = (m_st == 2);
            eb = (m_st != 0);
            ee = ew ? (10'b1 << m_type) : 10'b0;
            check(window == ew, "R3 model window", window, ew);
            check(busy == eb, "R12 model busy", busy, eb);
            check(type_en == ee, "R9 model type_en", type_en, ee);
        end
    end

    function automatic string len_tag(input int c);
        if (c == 0 || c == 1) return "R6 length";
        if (c == 4 || c == 5) return "R7 length";
        if (c == 8) return "R8 length";
        if (c == 6) return "R5 length";
        return "R4 length";
    endfunction

    // ev_kind: 0 none, 1 card_exit, 2 arith_done, 3 start of code 8 while busy
    task automatic run_op(input int code, input int exp_len, input int ev_at, input int ev_kind);
        int len, opos, guard, w0, elen;
        bit bad_en;
        len = 0; guard = 0; bad_en = 0;
        @(posedge clk); #1;
        op_code = 4'(code); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R12 busy after accept", busy, 1);
        while (!window && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        opos = pos;
        w0 = word_cnt;
        check(opos == ((code == 6) ? 16 : 0), "R2 open slot", opos, (code == 6) ? 16 : 0);
        while (window && len < 400) begin
            len++;
            if (type_en != (10'b1 << code)) bad_en = 1;
            if (ev_kind == 1) card_exit = (len == ev_at);
            if (ev_kind == 2) arith_done = (len == ev_at);
            if (ev_kind == 3) begin
                start = (len == ev_at);
                op_code = 4'd8;
            end
            @(negedge clk);
        end
        card_exit = 0; arith_done = 0; start = 0;
        elen = exp_len;
        if (exp_len < 0) elen = 32 * ((((slot - (w0 % 8)) % 8) + 8) % 8 + 1);
        check(len == elen, len_tag(code), len, elen);
        check(!bad_en, "R1 R9 enable bit", code, code);
        if (ev_kind == 3) check(len == 32 && !busy, "R10 busy start ignored", len, 32);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_unused(input int code);
        bit bad;
        bad = 0;
        @(posedge clk); #1;
        op_code = 4'(code); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (busy || window || type_en != 0) bad = 1;
        end
        check(!bad, "R11 unused code idle", code, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(window == 0 && busy == 0 && type_en == 0, "R12 reset outputs", {type_en, window, busy}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        run_op(0, -1, 0, 0);
        run_op(1, -1, 0, 0);
        run_op(2, 32, 0, 0);
        run_op(3, 32, 0, 0);
        run_op(4, 64, 40, 1);
        run_op(5, 32, 3, 1);
        run_op(6, 16, 0, 0);
        run_op(7, 32, 0, 0);
        run_op(8, 96, 70, 2);
        run_op(9, 32, 0, 0);
        run_op(2, 32, 5, 3);
        run_op(8, 32, 32, 2);
        run_unused(10);
        run_unused(15);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule